// File: doc/BRIEF.md
# Cassette Serial Shift Register

This block sits between a processor bus and the data line of a tape recorder. It holds a single byte-wide shift register and runs it in one of four mutually exclusive modes. In receive mode, serial bits arrive one per strobe from an external bit-timing stage. Each new bit enters the low end and the byte climbs toward the high end. After every eighth bit a receive-full flag is raised. In transmit mode the processor writes a byte, and the block then presents it high bit first on the serial output, one bit per strobe. Once the eighth bit has gone out, a transmit-empty flag is raised.

Both flags are cleared by writing ones to an acknowledge register, and each flag can drive the shared interrupt line through its own enable. The receive path has no overrun guard. A byte that is not collected keeps shifting, and its top bit is lost with every further strobe. Tone detection, modulation and bit-clock recovery live outside the block and appear here only as the strobe input.

Top module: `cas_shifter`

## Requirements
- R1: In receive mode (control bits [1:0] = 01), each cycle with `bit_stb` high shifts the register one place toward bit 7 and places `rx_bit` in bit 0. A read of address 0 returns the register.
- R2: The receive-full flag is set by the eighth accepted receive bit after the bit count was last cleared, and again by every eighth bit after that.
- R3: Strobes keep shifting an unread byte. The old bit 7 is discarded each time, and nothing blocks or flags the loss.
- R4: In transmit mode (control bits [1:0] = 10), a write to address 0 loads a byte. `tx_bit` then shows bit 7 first, and the next lower bit after each strobe. `tx_stb` equals `bit_stb` while a byte is in flight and is low otherwise.
- R5: The strobe that sends the eighth bit ends the transfer and sets the transmit-empty flag.
- R6: A write to address 1 clears the receive-full flag where data bit 0 is 1 and the transmit-empty flag where data bit 1 is 1. A zero in either bit leaves that flag alone.
- R7: In idle mode (00) and sound mode (11), strobes neither shift the register nor raise `tx_stb` nor set a flag.
- R8: The 3-bit position counter returns to zero when a control write changes the mode field, and when a transmit byte is loaded.
- R9: `irq` is high when the receive-full flag is set and control bit 2 is 1, or when the transmit-empty flag is set and control bit 3 is 1. Address 2 reads back the 4-bit control value.
- R10: In receive mode, a read of address 0 clears the receive-full flag and leaves shifting running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 interrupt acknowledge, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| bit_stb | input | 1 | One-cycle pulse per bit time from the timing stage |
| rx_bit | input | 1 | Received serial bit, valid with `bit_stb` |
| tx_bit | output | 1 | Serial output bit |
| tx_stb | output | 1 | Marks the cycle the current `tx_bit` is taken |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A position counter that is off by one shows up first on `irq`. The flag rises one strobe early or late, so an exact count of strobes before each check exposes it within a single byte. A shift in the wrong direction, or a lost bit, corrupts the byte returned by the next read of address 0. On the transmit side it corrupts `tx_bit` at the very next strobe. A stale busy state shows as `tx_stb` pulsing after the eighth bit or after a mode change.

// File: rtl/cas_shifter.sv
module cas_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         bit_stb,
  input  logic         rx_bit,
  output logic         tx_bit,
  output logic         tx_stb,
  output logic         irq
);
  localparam int CW = $clog2(W);
  localparam logic [1:0] M_RX = 2'b01, M_TX = 2'b10;

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic [3:0]    ctrl;
  logic          busy, rx_full, tx_empty;

  wire [1:0] mode    = ctrl[1:0];
  wire wr_data       = bus_sel & bus_we & (bus_addr == 2'd0);
  wire wr_ack        = bus_sel & bus_we & (bus_addr == 2'd1);
  wire wr_ctrl       = bus_sel & bus_we & (bus_addr == 2'd2);
  wire rd_data       = bus_sel & ~bus_we & (bus_addr == 2'd0);
  wire mode_chg      = wr_ctrl & (bus_wdata[1:0] != mode);
  wire rx_step       = bit_stb & (mode == M_RX) & ~mode_chg;
  wire tx_load       = wr_data & (mode == M_TX) & ~mode_chg;
  wire tx_step       = bit_stb & busy & (mode == M_TX) & ~mode_chg & ~tx_load;
  wire last          = (cnt == CW'(W - 1));

  assign tx_bit = sr[W-1] & (mode == M_TX);
  assign tx_stb = bit_stb & busy & (mode == M_TX);
  assign irq    = (rx_full & ctrl[2]) | (tx_empty & ctrl[3]);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = sr;
      2'd2:    bus_rdata = W'(ctrl);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0;
      cnt <= '0;
      ctrl <= '0;
      busy <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata[3:0];
      if (mode_chg) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else if (tx_load) begin
        sr   <= bus_wdata;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (rx_step) begin
        sr  <= {sr[W-2:0], rx_bit};
        cnt <= cnt + 1'b1;
      end else if (tx_step) begin
        sr  <= {sr[W-2:0], 1'b0};
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full  <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      if ((wr_ack & bus_wdata[0]) | (rd_data & (mode == M_RX))) rx_full <= 1'b0;
      if (wr_ack & bus_wdata[1]) tx_empty <= 1'b0;
      if (rx_step & last) rx_full <= 1'b1;
      if (tx_step & last) tx_empty <= 1'b1;
    end
  end
endmodule

// File: rtl/cas_shifter_chk.sv
module cas_shifter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_we,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic         bit_stb,
  input logic         tx_bit,
  input logic         tx_stb,
  input logic         irq,
  input logic [3:0]   ctrl,
  input logic         rx_full,
  input logic         tx_empty
);
  wire ctrl_wr = bus_sel & bus_we & (bus_addr == 2'd2);

  p_rx_full_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(bit_stb) && $past(ctrl[1:0]) == 2'b01);

  p_tx_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 2'd0 && ctrl[1:0] == 2'b10 && !ctrl_wr)
      |=> tx_bit == $past(bus_wdata[W-1]));

  p_tx_empty_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(tx_stb));

  p_quiet_modes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] == 2'b00 || ctrl[1:0] == 2'b11) |-> !tx_stb);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[2] && !ctrl[3]) |-> !irq);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 2'd1 && bus_wdata[1] && !tx_stb) |=> !tx_empty);
endmodule

bind cas_shifter cas_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bit_stb(bit_stb),
  .tx_bit(tx_bit), .tx_stb(tx_stb), .irq(irq), .ctrl(ctrl),
  .rx_full(rx_full), .tx_empty(tx_empty)
);

// File: tb/tb_cas_shifter.sv
module tb_cas_shifter;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0, bit_stb = 0, rx_bit = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic tx_bit, tx_stb, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cas_shifter dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rx(input logic b);
    @(negedge clk); bit_stb = 1; rx_bit = b;
    @(negedge clk); bit_stb = 0;
  endtask

  task automatic rx_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) rx(v[i]);
  endtask

  task automatic tx(output logic b, output logic s);
    @(negedge clk); bit_stb = 1; #1 b = tx_bit; s = tx_stb;
    @(negedge clk); bit_stb = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1 reset data", d, 8'h00);
    rd(2'd2, d); chk("R9 reset ctrl", d, 8'h00);
    chk("R9 reset irq", irq, 0);
  endtask

  task automatic t_rx;
    logic [7:0] d;
    wr(2'd2, 8'h05);
    rd(2'd2, d); chk("R9 ctrl readback", d, 8'h05);
    for (int i = 7; i >= 1; i--) rx(8'hA5 >> i);
    chk("R2 no flag after 7 bits", irq, 0);
    rx(1'b1);
    chk("R2 flag after 8 bits", irq, 1);
    rd(2'd0, d); chk("R1 received byte", d, 8'hA5);
    chk("R10 read clears flag", irq, 0);
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    rx(1); rx(0); rx(1);
    rd(2'd0, d); chk("R3 old top bits dropped", d, 8'h2D);
    chk("R10 shifting continued, no flag mid-byte", irq, 0);
    rx(0); rx(0); rx(1); rx(1); rx(0);
    chk("R2 flag again on next eighth", irq, 1);
    wr(2'd1, 8'h02);
    chk("R6 zero in bit0 keeps rx flag", irq, 1);
    wr(2'd1, 8'h01);
    chk("R6 one in bit0 clears rx flag", irq, 0);
  endtask

  task automatic t_mode_reset_cnt;
    rx(1); rx(1); rx(1);
    wr(2'd2, 8'h04); wr(2'd2, 8'h05);
    for (int i = 0; i < 7; i++) rx(0);
    chk("R8 count restarted on mode change", irq, 0);
    rx(0);
    chk("R8 flag after 8 fresh bits", irq, 1);
    wr(2'd1, 8'h01);
  endtask

  task automatic t_sound;
    logic [7:0] a, b;
    logic tb_b, tb_s;
    wr(2'd2, 8'h0F);
    rd(2'd0, a);
    for (int i = 0; i < 9; i++) begin
      tx(tb_b, tb_s);
      if (i == 0) chk("R7 no tx strobe in sound", tb_s, 0);
    end
    rd(2'd0, b); chk("R7 register frozen in sound", b, a);
    chk("R7 no flag in sound", irq, 0);
  endtask

  task automatic t_tx;
    logic b, s;
    logic [7:0] v = 8'h3C;
    wr(2'd2, 8'h0A);
    wr(2'd0, v);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) chk("R5 no flag before last bit", irq, 0);
      tx(b, s);
      chk("R4 tx strobe", s, 1);
      chk("R4 tx bit msb first", b, v[i]);
    end
    chk("R5 flag after last bit", irq, 1);
    tx(b, s); chk("R4 no strobe when idle", s, 0);
    wr(2'd1, 8'h01);
    chk("R6 bit0 does not clear tx flag", irq, 1);
    wr(2'd1, 8'h02);
    chk("R6 bit1 clears tx flag", irq, 0);
  endtask

  task automatic t_tx_reload;
    logic b, s;
    logic [7:0] v = 8'h81;
    wr(2'd0, 8'hFF);
    tx(b, s); tx(b, s); tx(b, s);
    wr(2'd0, v);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) chk("R8 load restarts count", irq, 0);
      tx(b, s);
      chk("R8 reloaded bit", b, v[i]);
    end
    chk("R5 flag after reloaded byte", irq, 1);
    wr(2'd2, 8'h02);
    chk("R9 masked tx flag", irq, 0);
    wr(2'd2, 8'h0A);
    chk("R9 unmasked tx flag", irq, 1);
    wr(2'd1, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_rx;
    t_overrun;
    t_mode_reset_cnt;
    t_sound;
    t_tx;
    t_tx_reload;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule